// File: doc/BRIEF.md
# Four-Bit Carry Lookahead Adder

This block adds two 4-bit operands and a carry-in without letting any carry travel from one bit position to the next. For each bit, a generate term (both operand bits set) and a propagate term (exactly one operand bit set) are formed. Every internal carry and the carry-out are then written as a flat two-level AND-OR expression of these terms and the carry-in. The logic depth therefore stays the same for every bit position.

The sum bit of each position is the propagate term XORed with the carry into that position. The block also drives a group generate output and a group propagate output. A wider adder or a second-level lookahead unit can use these two outputs to treat this slice as a single digit. The block has no clock and no state.

Top module: `cla4_adder`

## Requirements
- R1: `sum_o` equals the low four bits of the unsigned value `a_i + b_i + c_in`, for every input combination.
- R2: `c_out` equals bit 4 (the fifth bit) of the unsigned value `a_i + b_i + c_in`.
- R3: `grp_prop` is 1 exactly when every bit pair of `a_i` and `b_i` differs, that is, when `a_i ^ b_i == 4'hF`. Otherwise it is 0.
- R4: `grp_gen` is 1 exactly when `a_i + b_i` is 16 or more, whatever `c_in` is. Otherwise it is 0.
- R5: `c_out` always equals `grp_gen | (grp_prop & c_in)`, so that the slice can be chained through its group outputs.
- R6: When `grp_prop` is 1, `grp_gen` is 0 and `c_out` equals `c_in`. A carry-in passes through all four positions unchanged.
- R7: The block has no clock. After any input change, all outputs hold their final values without waiting for a clock edge. With all inputs at zero, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First operand |
| b_i | input | 4 | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum_o | output | 4 | Sum bits |
| c_out | output | 1 | Carry out of bit 3 |
| grp_gen | output | 1 | Slice generates a carry on its own |
| grp_prop | output | 1 | Slice passes the carry-in through |

## Verification
The carry-out can be produced in two ways: the slice generates a carry itself, or it passes the incoming carry along the full propagate path. A bit pattern can make the propagate path and the generate terms compete in the same evaluation. The bench provokes this with operand pairs whose XOR is all ones, at both carry-in values, and checks that the carry-out follows the carry-in while the group generate stays low. It also sweeps all 512 input combinations and compares the sum, the carry-out and both group outputs against arithmetic computed in the bench.

// File: rtl/cla4_adder.sv
module cla4_adder (
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       c_in,
  output logic [3:0] sum_o,
  output logic       c_out,
  output logic       grp_gen,
  output logic       grp_prop
);

  logic [3:0] g, p;
  logic [3:0] cy;

  assign g = a_i & b_i;
  assign p = a_i ^ b_i;

  assign cy[0] = c_in;
  assign cy[1] = g[0] | (p[0] & c_in);
  assign cy[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & c_in);
  assign cy[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
               | (p[2] & p[1] & p[0] & c_in);

  assign c_out = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
               | (p[3] & p[2] & p[1] & g[0])
               | (p[3] & p[2] & p[1] & p[0] & c_in);

  assign grp_gen  = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
                  | (p[3] & p[2] & p[1] & g[0]);
  assign grp_prop = &p;

  assign sum_o = p ^ cy;

endmodule

// File: rtl/cla4_adder_props.sv
module cla4_adder_props (
  input logic [3:0] a_i,
  input logic [3:0] b_i,
  input logic       c_in,
  input logic [3:0] sum_o,
  input logic       c_out,
  input logic       grp_gen,
  input logic       grp_prop
);
  logic [4:0] tot;
  logic [4:0] raw;
  assign tot = {1'b0, a_i} + {1'b0, b_i} + {4'b0, c_in};
  assign raw = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    p_sum_r1:    assert (sum_o == tot[3:0]);
    p_cout_r2:   assert (c_out == tot[4]);
    p_gprop_r3:  assert (grp_prop == ((a_i ^ b_i) == 4'hF));
    p_ggen_r4:   assert (grp_gen == raw[4]);
    p_chain_r5:  assert (c_out == (grp_gen | (grp_prop & c_in)));
    p_pass_r6:   assert (!grp_prop || (!grp_gen && c_out == c_in));
  end
endmodule

bind cla4_adder cla4_adder_props u_props (.*);

// File: tb/cla4_adder_test.sv
module cla4_adder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] a, b;
  logic cin;
  logic [3:0] sum;
  logic cout, gg, gp;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cla4_adder uut (
    .a_i(a), .b_i(b), .c_in(cin),
    .sum_o(sum), .c_out(cout), .grp_gen(gg), .grp_prop(gp)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s a=%0d b=%0d cin=%0d actual=%0d expected=%0d",
               req, a, b, cin, act, exp);
    end
  endtask

  task automatic apply(input int av, input int bv, input int cv);
    @(negedge clk);
    a = av[3:0]; b = bv[3:0]; cin = cv[0];
    #1;
  endtask

  task automatic t_zero;
    apply(0, 0, 0);
    chk("R7 sum", sum, 0);
    chk("R7 cout", cout, 0);
    chk("R7 gg", gg, 0);
    chk("R7 gp", gp, 0);
  endtask

  task automatic t_exhaustive;
    for (int i = 0; i < 512; i++) begin
      int av = i & 15;
      int bv = (i >> 4) & 15;
      int cv = (i >> 8) & 1;
      int t = av + bv + cv;
      apply(av, bv, cv);
      chk("R1 sum", sum, t & 15);
      chk("R2 cout", cout, (t >> 4) & 1);
      chk("R3 gp", gp, ((av ^ bv) == 15) ? 1 : 0);
      chk("R4 gg", gg, (av + bv >= 16) ? 1 : 0);
      chk("R5 chain", cout, gg | (gp & cin));
    end
  endtask

  task automatic t_full_propagate;
    for (int av = 0; av < 16; av++) begin
      for (int cv = 0; cv < 2; cv++) begin
        apply(av, av ^ 15, cv);
        chk("R6 cout", cout, cv);
        chk("R6 gg", gg, 0);
        chk("R6 sum", sum, (15 + cv) & 15);
      end
    end
  endtask

  task automatic t_no_clock;
    apply(15, 1, 0);
    a = 4'd7; b = 4'd8; cin = 1'b1;
    #0.5;
    chk("R7 settle sum", sum, 0);
    chk("R7 settle cout", cout, 1);
  endtask

  initial begin
    a = 0; b = 0; cin = 0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_zero();
    t_exhaustive();
    t_full_propagate();
    t_no_clock();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule